// File: doc/BRIEF.md
# Interpolating DDS Sine Oscillator

This block is a direct digital synthesis oscillator. It turns a phase increment into a stream of 12-bit unipolar sine samples, one for each sample tick. The intended tick rate is a steady 96 kHz. Each enabled tick adds the increment to a 32-bit phase register. The top byte of the new phase picks an entry in a 256-entry sine table. The byte below it gives a fractional weight, and the block blends linearly between that entry and the next one. This keeps the waveform smooth at high output frequencies, where a plain table lookup would produce steps.

A mute control gates the oscillator. On a tick with the enable low, the block emits the mid-scale code 2048, which is silence for a unipolar converter. The phase register keeps its value during mute, so sound resumes from the same point in the cycle. Each result appears on the output one clock after its tick, together with a one-cycle valid strobe. The result then stays on the output until the next tick.

Top module: `dds_sine_gen`

## Requirements
- R1: While rst_ni is low and after it rises, sample_o is 2048, valid_o is 0 and the phase register is zero, so the first enabled tick with increment X yields the sample for phase X.
- R2: valid_o is 1 in exactly the clock cycle that follows a clock edge where tick_i was sampled high, and 0 in every other cycle.
- R3: On a tick with en_i high, the phase becomes (phase + phase_inc_i) mod 2^32, and sample_o is computed from that new phase.
- R4: The table index is phase bits [31:24] and the fraction is phase bits [23:16]; phase bits [15:0] have no effect on sample_o.
- R5: Table entry k equals round(2048 + 2047*sin(2*pi*k/256)), giving 2048 at k=0, 4095 at k=64 and 1 at k=192.
- R6: sample_o = a + floor((b - a) * frac / 256), where a is entry[index], b is entry[index+1] and frac is the unsigned fraction; the result is limited to 0..4095.
- R7: The next-entry index wraps from 255 to 0.
- R8: On a tick with en_i low, sample_o becomes 2048 and the phase register keeps its value.
- R9: Between ticks, sample_o keeps its last value and changes to en_i or phase_inc_i have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample tick, one cycle wide, nominally 96 kHz |
| en_i | input | 1 | Audio enable; low mutes to mid-scale |
| phase_inc_i | input | 32 | Phase increment added on each enabled tick |
| sample_o | output | 12 | Unipolar output sample |
| valid_o | output | 1 | One-cycle strobe, high the cycle after a tick |

## Verification
Two cases are hard to reach from the ports. One is the interpolation across the table seam, from index 255 back to 0. The other is proof that the low sixteen phase bits are ignored. Both need the hidden phase register to sit at a chosen value. The bench gets there by resetting the phase to zero and applying one enabled tick with a crafted increment, such as 0xFF80_0000 to land at index 255 with half weight. For the low bits, it compares two fresh runs whose increments differ only below bit 16. Mute hold is shown by re-enabling after muted ticks and checking that the next sample continues from the held phase, not from a phase that moved.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam real PI = 3.14159265358979323846;

  // round(mid + (mid-1)*sin(2*pi*k/depth)), mid = 2^(smp_w-1)
  function automatic int sine_entry(input int k, input int depth, input int smp_w);
    real mid;
    real amp;
    real ang;
    mid = real'(1 << (smp_w - 1));
    amp = mid - 1.0;
    ang = 2.0 * PI * real'(k) / real'(depth);
    return $rtoi(mid + amp * $sin(ang) + 0.5);
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32,
  parameter int TOP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [TOP_W-1:0] phase_next_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;

  assign acc_sum      = acc_q + inc_i;
  assign phase_next_o = acc_sum[ACC_W-1 -: TOP_W];
  assign acc_o        = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= acc_sum;
  end
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
  import dds_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int SMP_W = 12
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [SMP_W-1:0] cur_o,
  output logic [SMP_W-1:0] nxt_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [SMP_W-1:0] rom [DEPTH];
  logic [IDX_W-1:0] idx_nxt;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = SMP_W'(sine_entry(g, DEPTH, SMP_W));
  end

  assign idx_nxt = idx_i + IDX_W'(1);  // wraps at end of table
  assign cur_o   = rom[idx_i];
  assign nxt_o   = rom[idx_nxt];
endmodule

// File: rtl/dds_interp.sv
module dds_interp #(
  parameter int SMP_W  = 12,
  parameter int FRAC_W = 8
) (
  input  logic [SMP_W-1:0]  a_i,
  input  logic [SMP_W-1:0]  b_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [SMP_W-1:0]  y_o
);
  localparam int PW = SMP_W + FRAC_W + 2;
  localparam logic [SMP_W-1:0] Y_MAX = '1;

  logic signed [PW-1:0] diff;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] step;
  logic signed [PW-1:0] sum;

  always_comb begin
    diff = $signed({{(PW-SMP_W){1'b0}}, b_i}) - $signed({{(PW-SMP_W){1'b0}}, a_i});
    prod = diff * $signed({{(PW-FRAC_W){1'b0}}, frac_i});
    step = prod >>> FRAC_W;
    sum  = $signed({{(PW-SMP_W){1'b0}}, a_i}) + step;
    if (sum < 0)
      y_o = '0;
    else if (sum > $signed({{(PW-SMP_W){1'b0}}, Y_MAX}))
      y_o = Y_MAX;
    else
      y_o = sum[SMP_W-1:0];
  end
endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen #(
  parameter int ACC_W  = 32,
  parameter int IDX_W  = 8,
  parameter int FRAC_W = 8,
  parameter int SMP_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] phase_inc_i,
  output logic [SMP_W-1:0] sample_o,
  output logic             valid_o
);
  localparam int TOP_W = IDX_W + FRAC_W;
  localparam logic [SMP_W-1:0] MID = SMP_W'(1 << (SMP_W - 1));

  logic [ACC_W-1:0]  acc_q;
  logic [TOP_W-1:0]  phase_top;
  logic [IDX_W-1:0]  idx;
  logic [FRAC_W-1:0] frac;
  logic [SMP_W-1:0]  ent_a;
  logic [SMP_W-1:0]  ent_b;
  logic [SMP_W-1:0]  interp_y;
  logic [SMP_W-1:0]  sample_q;
  logic              valid_q;

  dds_phase_acc #(.ACC_W(ACC_W), .TOP_W(TOP_W)) u_acc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (tick_i & en_i),
    .inc_i        (phase_inc_i),
    .acc_o        (acc_q),
    .phase_next_o (phase_top)
  );

  assign idx  = phase_top[TOP_W-1 -: IDX_W];
  assign frac = phase_top[FRAC_W-1:0];

  dds_sine_rom #(.IDX_W(IDX_W), .SMP_W(SMP_W)) u_rom (
    .idx_i (idx),
    .cur_o (ent_a),
    .nxt_o (ent_b)
  );

  dds_interp #(.SMP_W(SMP_W), .FRAC_W(FRAC_W)) u_interp (
    .a_i    (ent_a),
    .b_i    (ent_b),
    .frac_i (frac),
    .y_o    (interp_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= MID;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= tick_i;
      if (tick_i) sample_q <= en_i ? interp_y : MID;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/dds_sine_gen_chk.sv
module dds_sine_gen_chk #(
  parameter int ACC_W = 32,
  parameter int SMP_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             en_i,
  input logic [ACC_W-1:0] phase_inc_i,
  input logic [ACC_W-1:0] acc_i,
  input logic [SMP_W-1:0] sample_i,
  input logic             valid_i
);
  localparam logic [SMP_W-1:0] MID = SMP_W'(1 << (SMP_W - 1));

  a_r2_valid_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> valid_i);

  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !valid_i);

  a_r3_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i) |=> acc_i == $past(acc_i) + $past(phase_inc_i));

  a_r8_mute_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !en_i) |=> sample_i == MID);

  a_r8_mute_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !en_i) |=> $stable(acc_i));

  a_r9_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(sample_i) && $stable(acc_i)));
endmodule

bind dds_sine_gen dds_sine_gen_chk #(.ACC_W(ACC_W), .SMP_W(SMP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .en_i        (en_i),
  .phase_inc_i (phase_inc_i),
  .acc_i       (acc_q),
  .sample_i    (sample_o),
  .valid_i     (valid_o)
);

// File: tb/dds_sine_gen_bench.sv
module dds_sine_gen_bench;
  localparam int NV = 12;
  // {enable, increment}
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 32'h0100_0000}, {1'b1, 32'h0080_0000}, {1'b1, 32'h0123_4567},
    {1'b0, 32'h4000_0000}, {1'b1, 32'h3FFF_FFFF}, {1'b1, 32'h7FFF_0000},
    {1'b1, 32'h0000_FFFF}, {1'b0, 32'hFFFF_FFFF}, {1'b1, 32'h8000_0000},
    {1'b1, 32'hFFFF_FFFF}, {1'b1, 32'h1555_5555}, {1'b1, 32'hC0C0_C0C0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        en = 1'b0;
  logic [31:0] inc = '0;
  logic [11:0] smp;
  logic        vld;

  int          n_vec = 0;
  int          n_bad = 0;
  logic [31:0] ph = '0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dds_sine_gen u_dds_sine_gen (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en),
    .phase_inc_i(inc), .sample_o(smp), .valid_o(vld)
  );

  function automatic int tbl(input int k);
    real w;
    w = 2.0 * 3.14159265358979323846 * real'(k % 256) / 256.0;
    return $rtoi(2048.0 + 2047.0 * $sin(w) + 0.5);
  endfunction

  function automatic int model(input logic [31:0] p);
    int a, b, f, y;
    a = tbl(int'(p[31:24]));
    b = tbl(int'(p[31:24]) + 1);
    f = int'(p[23:16]);
    y = a + $rtoi($floor(real'((b - a) * f) / 256.0));
    if (y < 0) y = 0;
    if (y > 4095) y = 4095;
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ph = '0;
  endtask

  // one tick; returns the sample seen in the cycle after it
  task automatic do_tick(input bit e, input logic [31:0] d, output int s);
    @(negedge clk);
    tick = 1'b1; en = e; inc = d;
    @(negedge clk);
    tick = 1'b0;
    if (e) ph = ph + d;
    s = int'(smp);
    chk(vld === 1'b1, "R2 valid after tick", int'(vld), 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int s, s2, held;
    // R1: reset state
    @(negedge clk);
    chk(smp == 12'd2048, "R1 sample in reset", int'(smp), 2048);
    chk(vld == 1'b0, "R1 valid in reset", int'(vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp == 12'd2048 && vld == 1'b0, "R1 after release", int'(smp), 2048);

    // vector walk: R3, R6, R8, R9
    for (int i = 0; i < NV; i++) begin
      bit e;
      e = VEC[i][32];
      do_tick(e, VEC[i][31:0], s);
      if (e) chk(s == model(ph), "R3 R6 enabled sample", s, model(ph));
      else   chk(s == 2048, "R8 muted sample", s, 2048);
      en = ~e; inc = ~VEC[i][31:0];
      repeat (3) @(negedge clk);
      chk(int'(smp) == s, "R9 hold between ticks", int'(smp), s);
      chk(vld == 1'b0, "R2 no valid without tick", int'(vld), 0);
    end

    // R8: muted ticks keep phase, resume continues from it
    do_reset();
    do_tick(1'b1, 32'h1000_0000, s);
    do_tick(1'b0, 32'h2000_0000, s);
    do_tick(1'b0, 32'h2000_0000, s);
    do_tick(1'b1, 32'h0400_0000, s);
    chk(s == model(32'h1400_0000), "R8 phase held while muted", s, model(32'h1400_0000));

    // R1: first enabled tick after reset starts from phase 0
    do_reset();
    do_tick(1'b1, 32'h2A00_0000, s);
    chk(s == tbl(42), "R1 phase zero after reset", s, tbl(42));

    // R5: table points
    do_reset();
    do_tick(1'b1, 32'h0000_0000, s);
    chk(s == 2048, "R5 entry 0", s, 2048);
    do_tick(1'b1, 32'h4000_0000, s);
    chk(s == 4095, "R5 entry 64", s, 4095);
    do_tick(1'b1, 32'h8000_0000, s);
    chk(s == 1, "R5 entry 192", s, 1);

    // R7: interpolation across the 255 -> 0 seam
    do_reset();
    do_tick(1'b1, 32'hFF80_0000, s);
    s2 = tbl(255) + $rtoi($floor(real'((tbl(0) - tbl(255)) * 128) / 256.0));
    chk(s == s2, "R7 wrap to entry 0", s, s2);
    chk(s > tbl(255) && s < tbl(0), "R7 between seam entries", s, s2);

    // R4: low phase bits ignored
    do_reset();
    do_tick(1'b1, 32'h1234_FFFF, held);
    do_reset();
    do_tick(1'b1, 32'h1234_0000, s);
    chk(s == held, "R4 low bits ignored", s, held);
    chk(s == model(32'h1234_0000), "R4 index and fraction", s, model(32'h1234_0000));

    // R6: negative slope fraction rounds toward minus infinity
    do_reset();
    do_tick(1'b1, 32'h50C3_0000, s);
    chk(s == model(32'h50C3_0000), "R6 falling slope", s, model(32'h50C3_0000));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule